// File: doc/BRIEF.md
# BCD Real-Time Calendar Core

This block keeps wall-clock time as packed BCD fields: seconds, minutes, hours, day of week, day of month, month and a four-digit year. A single-cycle enable pulse from an external divider, `tick`, arrives at 256 Hz. An internal 8-bit prescaler counts these pulses. Its upper seven bits form a readable sub-second count that advances at 128 Hz, and each wrap of the prescaler advances the seconds by one. A small register file lets a bus master do several things: stop and start the count, clear the prescaler, load any time field, round to the nearest minute, and pick a periodic interrupt rate.

Software reads the time as several registers in turn. It clears the carry flag first and checks the flag again at the end. If the flag is set, a second went by during the read and the read must be repeated. Two interrupt outputs report the carry event and the periodic event. Each one is gated by its own enable or rate field.

Register addresses (word index on `addr`): 0 sub-second (read only), 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day of month, 6 month, 7 year (16 bits, century in the upper byte), 8 control A, 9 control B.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, the registers read as follows. Sub-second, seconds, minutes, hours and weekday read 0. Day of month reads 0x01, month reads 0x01 and year reads 0x2000. Both control registers read 0x00 and both interrupt outputs are low.
- R2: A write to any register at addresses 1 to 7 is stored only while the core is not running. The core is running when control B bit 0 (start) is 1, bit 3 (enable) is 1 and bit 1 (prescaler clear) is 0. While the core is running, such a write has no effect.
- R3: While the core runs, each `tick` pulse increments the 8-bit prescaler. Address 0 reads the prescaler shifted right by one. Seconds advance on the tick that wraps the prescaler from 255 to 0. While prescaler clear is 1, the prescaler holds at 0. While the core is not running, neither the prescaler nor the time changes.
- R4: The fields roll over in BCD as follows. Seconds and minutes wrap from 0x59 to 0x00, hours wrap from 0x23 to 0x00, and weekday wraps from 0x06 to 0x00. Each wrap carries into the next field up.
- R5: Day of month wraps to 0x01 after the last day of the month. February has 29 days when the four-digit year is divisible by 4, except for years divisible by 100 that are not divisible by 400. Month wraps from 0x12 to 0x01 and carries into the year. The year's low byte wraps from 0x99 to 0x00 and carries into the century byte, and the century byte wraps from 0x99 to 0x00.
- R6: Control A bit 7 is the carry flag. It sets on every seconds advance caused by the prescaler. A write to control A with bit 7 at 0 clears it, and a write with bit 7 at 1 leaves it unchanged. If a seconds advance and a clearing write happen in the same cycle, the flag ends up set.
- R7: `carry_irq` is high exactly when the carry flag is 1 and control A bit 4 (carry interrupt enable) is 1.
- R8: Writing control B with bit 2 set rounds the time to the nearest minute. If seconds are 0x30 or more, seconds become 0x00 and the minute advances, carrying through the calendar. Otherwise seconds become 0x00 and nothing else changes. The prescaler also clears to 0, and bit 2 always reads back as 0.
- R9: Control B bits 6:4 select the periodic rate. Code 0 turns the periodic event off. Codes 1 to 7 set control B bit 7 (the periodic flag) every 1, 2, 4, 16, 64, 128 and 256 running ticks, counted from a cleared prescaler. The flag stays set until a control B write with bit 7 at 0, and a write with bit 7 at 1 leaves it unchanged.
- R10: `periodic_irq` is high exactly when the periodic flag is 1 and the rate select is nonzero.
- R11: Control B reads back the fields last written to it in the same bit positions: start at bit 0, prescaler clear at bit 1, enable at bit 3 and rate at bits 6:4. Bit 2 reads as 0 and bit 7 reads as the periodic flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable pulse at 256 Hz |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| carry_irq | output | 1 | Carry interrupt request |
| periodic_irq | output | 1 | Periodic interrupt request |

## Verification
The calendar advance is driven by loading a time, running exactly one second of ticks and comparing every field against an integer calendar model. Directed corner starts cover the end of a month, leap and non-leap Februaries in century years, and the wrap of year 9999. These separate the month-length and leap decisions from the simple BCD carries. Random starts, biased toward 59 seconds, 59 minutes and 23 hours, exercise the carry chain at different depths. Periodic codes are each measured one tick before and on the expected tick, which tells a wrong divider apart from a wrong code mapping.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

  typedef struct packed {
    logic [15:0] year;
    logic [7:0]  mon;
    logic [7:0]  mday;
    logic [7:0]  wday;
    logic [7:0]  hour;
    logic [7:0]  min;
    logic [7:0]  sec;
  } rtc_time_t;

  // register word addresses (counter order is fixed by read sequencing)
  localparam logic [3:0] A_SUB  = 4'd0;
  localparam logic [3:0] A_SEC  = 4'd1;
  localparam logic [3:0] A_MIN  = 4'd2;
  localparam logic [3:0] A_HOUR = 4'd3;
  localparam logic [3:0] A_WDAY = 4'd4;
  localparam logic [3:0] A_MDAY = 4'd5;
  localparam logic [3:0] A_MON  = 4'd6;
  localparam logic [3:0] A_YEAR = 4'd7;
  localparam logic [3:0] A_CTLA = 4'd8;
  localparam logic [3:0] A_CTLB = 4'd9;

  // control bit positions
  localparam int CA_CFLAG = 7;
  localparam int CA_CIE   = 4;
  localparam int CB_START = 0;
  localparam int CB_PCLR  = 1;
  localparam int CB_ADJ   = 2;
  localparam int CB_EN    = 3;
  localparam int CB_RATE  = 4;
  localparam int CB_PFLAG = 7;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // packed BCD 00..99 divisible by four
  function automatic logic bcd_div4(input logic [7:0] v);
    if (v[4]) bcd_div4 = (v[3:0] == 4'd2) || (v[3:0] == 4'd6);
    else      bcd_div4 = (v[3:0] == 4'd0) || (v[3:0] == 4'd4) || (v[3:0] == 4'd8);
  endfunction

  function automatic logic is_leap(input logic [15:0] y);
    if (y[7:0] == 8'h00) is_leap = bcd_div4(y[15:8]);
    else                 is_leap = bcd_div4(y[7:0]);
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      month_days = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_days = 8'h30;
      default:                    month_days = 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          clr,
  input  logic [2:0]    rate,
  output logic [PW-1:0] cnt,
  output logic          sec_tick,
  output logic          per_evt
);

  logic [PW-1:0] cnt_q, cnt_d, cnt_inc, mask;
  int unsigned   sh;

  assign cnt_inc = cnt_q + 1'b1;

  // rate code -> number of low prescaler bits that must be zero
  always_comb begin
    case (rate)
      3'd1:    sh = 0;
      3'd2:    sh = 1;
      3'd3:    sh = 2;
      3'd4:    sh = 4;
      3'd5:    sh = PW - 2;
      3'd6:    sh = PW - 1;
      default: sh = PW;
    endcase
    mask = ~({PW{1'b1}} << sh);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr)              cnt_d = '0;
    else if (run && tick) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign sec_tick = !clr && run && tick && (cnt_q == {PW{1'b1}});
  assign per_evt  = !clr && run && tick && (rate != 3'd0) && ((cnt_inc & mask) == '0);
  assign cnt      = cnt_q;

endmodule

// File: rtl/rtc_ctrl.sv
`timescale 1ns/1ps
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_a,
  input  logic       wr_b,
  input  logic [7:0] wd,
  input  logic       sec_tick,
  input  logic       per_evt,
  output logic       cflag,
  output logic       cie,
  output logic       start,
  output logic       pclr,
  output logic       en,
  output logic [2:0] rate,
  output logic       pflag,
  output logic       adj_pulse,
  output logic       run
);

  logic       cflag_d, cie_d, start_d, pclr_d, en_d, pflag_d;
  logic [2:0] rate_d;

  always_comb begin
    cflag_d = cflag;
    cie_d   = cie;
    start_d = start;
    pclr_d  = pclr;
    en_d    = en;
    rate_d  = rate;
    pflag_d = pflag;
    if (wr_a) begin
      cie_d = wd[CA_CIE];
      if (!wd[CA_CFLAG]) cflag_d = 1'b0;
    end
    if (sec_tick) cflag_d = 1'b1;
    if (wr_b) begin
      start_d = wd[CB_START];
      pclr_d  = wd[CB_PCLR];
      en_d    = wd[CB_EN];
      rate_d  = wd[CB_RATE +: 3];
      if (!wd[CB_PFLAG]) pflag_d = 1'b0;
    end
    if (per_evt) pflag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cflag <= 1'b0;
      cie   <= 1'b0;
      start <= 1'b0;
      pclr  <= 1'b0;
      en    <= 1'b0;
      rate  <= 3'd0;
      pflag <= 1'b0;
    end else begin
      cflag <= cflag_d;
      cie   <= cie_d;
      start <= start_d;
      pclr  <= pclr_d;
      en    <= en_d;
      rate  <= rate_d;
      pflag <= pflag_d;
    end
  end

  assign adj_pulse = wr_b & wd[CB_ADJ];
  assign run       = start & en & ~pclr;

endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic        adj,
  input  logic        run,
  input  logic        wr_en,
  input  logic [3:0]  waddr,
  input  logic [15:0] wdata,
  output rtc_time_t   t
);

  rtc_time_t t_q, t_d;
  logic roll_min, roll_hr, roll_day, roll_mon, roll_yr;

  always_comb begin
    t_d      = t_q;
    roll_min = 1'b0;
    roll_hr  = 1'b0;
    roll_day = 1'b0;
    roll_mon = 1'b0;
    roll_yr  = 1'b0;

    if (adj) begin
      t_d.sec  = 8'h00;
      roll_min = (t_q.sec >= 8'h30);
    end else if (step) begin
      if (t_q.sec >= 8'h59) begin
        t_d.sec  = 8'h00;
        roll_min = 1'b1;
      end else begin
        t_d.sec = bcd_inc(t_q.sec);
      end
    end else if (wr_en && !run) begin
      case (waddr)
        A_SEC:   t_d.sec  = wdata[7:0];
        A_MIN:   t_d.min  = wdata[7:0];
        A_HOUR:  t_d.hour = wdata[7:0];
        A_WDAY:  t_d.wday = wdata[7:0];
        A_MDAY:  t_d.mday = wdata[7:0];
        A_MON:   t_d.mon  = wdata[7:0];
        A_YEAR:  t_d.year = wdata;
        default: ;
      endcase
    end

    if (roll_min) begin
      if (t_q.min >= 8'h59) begin t_d.min = 8'h00; roll_hr = 1'b1; end
      else t_d.min = bcd_inc(t_q.min);
    end
    if (roll_hr) begin
      if (t_q.hour >= 8'h23) begin t_d.hour = 8'h00; roll_day = 1'b1; end
      else t_d.hour = bcd_inc(t_q.hour);
    end
    if (roll_day) begin
      t_d.wday = (t_q.wday >= 8'h06) ? 8'h00 : bcd_inc(t_q.wday);
      if (t_q.mday >= month_days(t_q.mon, is_leap(t_q.year))) begin
        t_d.mday = 8'h01;
        roll_mon = 1'b1;
      end else begin
        t_d.mday = bcd_inc(t_q.mday);
      end
    end
    if (roll_mon) begin
      if (t_q.mon >= 8'h12) begin t_d.mon = 8'h01; roll_yr = 1'b1; end
      else t_d.mon = bcd_inc(t_q.mon);
    end
    if (roll_yr) begin
      if (t_q.year[7:0] >= 8'h99) begin
        t_d.year[7:0]  = 8'h00;
        t_d.year[15:8] = (t_q.year[15:8] >= 8'h99) ? 8'h00 : bcd_inc(t_q.year[15:8]);
      end else begin
        t_d.year[7:0] = bcd_inc(t_q.year[7:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q.sec  <= 8'h00;
      t_q.min  <= 8'h00;
      t_q.hour <= 8'h00;
      t_q.wday <= 8'h00;
      t_q.mday <= 8'h01;
      t_q.mon  <= 8'h01;
      t_q.year <= 16'h2000;
    end else begin
      t_q <= t_d;
    end
  end

  assign t = t_q;

endmodule

// File: rtl/bcd_rtc_core.sv
`timescale 1ns/1ps
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          carry_irq,
  output logic          periodic_irq
);

  localparam int SUBW = PW - 1;

  logic          rst_m, rst_sn;
  logic          wr_a, wr_b;
  logic          cflag, cie, start, pclr, en, pflag, adj_pulse, run;
  logic [2:0]    rate;
  logic [PW-1:0] presc;
  logic          sec_tick, per_evt;
  logic [3:0]    raddr;
  rtc_time_t     tm;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m  <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_m  <= 1'b1;
      rst_sn <= rst_m;
    end
  end

  assign raddr = 4'(addr);
  assign wr_a  = wr_en && (raddr == A_CTLA);
  assign wr_b  = wr_en && (raddr == A_CTLB);

  rtc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sn), .wr_a(wr_a), .wr_b(wr_b), .wd(wdata[7:0]),
    .sec_tick(sec_tick), .per_evt(per_evt),
    .cflag(cflag), .cie(cie), .start(start), .pclr(pclr), .en(en),
    .rate(rate), .pflag(pflag), .adj_pulse(adj_pulse), .run(run)
  );

  rtc_prescaler #(.PW(PW)) u_presc (
    .clk(clk), .rst_n(rst_sn), .tick(tick), .run(run),
    .clr(pclr | adj_pulse), .rate(rate),
    .cnt(presc), .sec_tick(sec_tick), .per_evt(per_evt)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_sn), .step(sec_tick), .adj(adj_pulse), .run(run),
    .wr_en(wr_en), .waddr(raddr), .wdata(wdata[15:0]), .t(tm)
  );

  always_comb begin
    rdata = '0;
    case (raddr)
      A_SUB:   rdata[SUBW-1:0] = presc[PW-1:1];
      A_SEC:   rdata[7:0]  = tm.sec;
      A_MIN:   rdata[7:0]  = tm.min;
      A_HOUR:  rdata[7:0]  = tm.hour;
      A_WDAY:  rdata[7:0]  = tm.wday;
      A_MDAY:  rdata[7:0]  = tm.mday;
      A_MON:   rdata[7:0]  = tm.mon;
      A_YEAR:  rdata[15:0] = tm.year;
      A_CTLA: begin
        rdata[CA_CFLAG] = cflag;
        rdata[CA_CIE]   = cie;
      end
      A_CTLB: begin
        rdata[CB_START]      = start;
        rdata[CB_PCLR]       = pclr;
        rdata[CB_EN]         = en;
        rdata[CB_RATE +: 3]  = rate;
        rdata[CB_PFLAG]      = pflag;
      end
      default: ;
    endcase
  end

  assign carry_irq    = cflag & cie;
  assign periodic_irq = pflag & (rate != 3'd0);

endmodule

// File: rtl/rtc_core_checker.sv
`timescale 1ns/1ps
module rtc_core_checker #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          sec_tick,
  input logic          per_evt,
  input logic          adj_pulse,
  input logic          run,
  input logic          pclr,
  input logic          cflag,
  input logic          pflag,
  input logic [PW-1:0] presc,
  input logic [7:0]    sec
);

  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (!run && !pclr && !adj_pulse) |=> $stable(presc));

  p_sec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (sec_tick && sec == 8'h59) |=> (sec == 8'h00));

  p_carry_set_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    sec_tick |=> cflag);

  p_adj_clear_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    adj_pulse |=> (presc == '0));

  p_pflag_set_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    per_evt |=> pflag);

endmodule

bind bcd_rtc_core rtc_core_checker #(.PW(PW)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .sec_tick(sec_tick), .per_evt(per_evt),
  .adj_pulse(adj_pulse), .run(run), .pclr(pclr), .cflag(cflag),
  .pflag(pflag), .presc(presc), .sec(tm.sec)
);

// File: tb/bcd_rtc_core_test.sv
`timescale 1ns/1ps
module bcd_rtc_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        carry_irq, periodic_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int ty, tmo, td, twd, th, tmi, ts;

  always #2.5 clk = ~clk;

  bcd_rtc_core uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .carry_irq(carry_irq), .periodic_irq(periodic_irq)
  );

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = a[3:0]; wdata = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    addr = a[3:0];
    #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk); tick = 1'b0;
    end
  endtask

  function automatic int mlen(input int y, input int m);
    bit leap = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    case (m)
      2: return leap ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  function automatic logic [7:0] b2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [63:0] exp_time();
    return {b2b(ty / 100), b2b(ty % 100), b2b(tmo), b2b(td), b2b(twd), b2b(th), b2b(tmi), b2b(ts)};
  endfunction

  task automatic model_sec();
    ts++;
    if (ts == 60) begin
      ts = 0; tmi++;
      if (tmi == 60) begin
        tmi = 0; th++;
        if (th == 24) begin
          th = 0; twd = (twd + 1) % 7; td++;
          if (td > mlen(ty, tmo)) begin
            td = 1; tmo++;
            if (tmo == 13) begin tmo = 1; ty = (ty + 1) % 10000; end
          end
        end
      end
    end
  endtask

  task automatic set_t(input int y, mo, d, wd, h, mi, s);
    ty = y; tmo = mo; td = d; twd = wd; th = h; tmi = mi; ts = s;
  endtask

  task automatic load_t();
    wr(9, 0);
    wr(1, b2b(ts)); wr(2, b2b(tmi)); wr(3, b2b(th)); wr(4, b2b(twd));
    wr(5, b2b(td)); wr(6, b2b(tmo)); wr(7, {b2b(ty / 100), b2b(ty % 100)});
  endtask

  task automatic read_t(output logic [63:0] v);
    logic [15:0] r;
    v = '0;
    rd(7, r); v[63:48] = r;
    rd(6, r); v[47:40] = r[7:0];
    rd(5, r); v[39:32] = r[7:0];
    rd(4, r); v[31:24] = r[7:0];
    rd(3, r); v[23:16] = r[7:0];
    rd(2, r); v[15:8]  = r[7:0];
    rd(1, r); v[7:0]   = r[7:0];
  endtask

  initial begin
    logic [15:0] r;
    logic [63:0] v;
    int period [1:7];
    period[1] = 1; period[2] = 2; period[3] = 4; period[4] = 16;
    period[5] = 64; period[6] = 128; period[7] = 256;
    void'($urandom(32'd20240229));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 10; a++) begin
      logic [15:0] e;
      case (a)
        5, 6: e = 16'h0001;
        7: e = 16'h2000;
        default: e = 16'h0000;
      endcase
      rd(a, r);
      chk($sformatf("R1 reset addr %0d", a), r, e);
    end
    chk("R1 irq outputs", {carry_irq, periodic_irq}, 2'b00);

    // R2: writes accepted when stopped, ignored when running
    set_t(2023, 6, 15, 3, 10, 20, 30);
    load_t();
    read_t(v);
    chk("R2 load readback", v, exp_time());
    wr(9, 9); wr(1, 8'h33); wr(9, 0);
    rd(1, r);
    chk("R2 write while running ignored", r, 16'h0030);
    wr(9, 1); wr(1, 8'h44);
    rd(1, r);
    chk("R2 write with enable low stored", r, 16'h0044);
    wr(1, 8'h30);

    // R3: prescaler and second advance
    wr(9, 2); wr(9, 9);
    ticks(10);
    rd(0, r); chk("R3 sub-second after 10 ticks", r, 16'd5);
    ticks(245);
    rd(1, r); chk("R3 no advance at 255 ticks", r, 16'h0030);
    ticks(1);
    rd(1, r); chk("R3 advance at 256 ticks", r, 16'h0031);
    rd(0, r); chk("R3 sub-second wrapped", r, 16'd0);
    wr(9, 8'h0B); ticks(300);
    rd(1, r); chk("R3 prescaler clear holds seconds", r, 16'h0031);
    rd(0, r); chk("R3 prescaler clear holds sub-second", r, 16'd0);
    wr(9, 8'h01); ticks(300);
    rd(1, r); chk("R3 enable low holds", r, 16'h0031);

    // R6 / R7: carry flag and interrupt
    rd(8, r); chk("R6 carry flag set by advance", r, 16'h0080);
    chk("R7 irq masked without enable", carry_irq, 1'b0);
    wr(8, 8'h90);
    rd(8, r); chk("R6 write one keeps flag", r, 16'h0090);
    chk("R7 irq with flag and enable", carry_irq, 1'b1);
    wr(8, 8'h10);
    rd(8, r); chk("R6 write zero clears flag", r, 16'h0010);
    chk("R7 irq drops with flag", carry_irq, 1'b0);
    wr(8, 0);

    // R4 / R5: one-second advance from directed and random starts
    for (int i = 0; i < 40; i++) begin
      case (i)
        0: set_t(2023, 12, 31, 6, 23, 59, 59);
        1: set_t(2024, 2, 28, 3, 23, 59, 59);
        2: set_t(2024, 2, 29, 4, 23, 59, 59);
        3: set_t(2100, 2, 28, 0, 23, 59, 59);
        4: set_t(2000, 2, 28, 1, 23, 59, 59);
        5: set_t(1999, 12, 31, 5, 23, 59, 59);
        6: set_t(9999, 12, 31, 6, 23, 59, 59);
        7: set_t(2023, 4, 30, 2, 23, 59, 59);
        default: begin
          ty  = $urandom_range(9999, 0);
          tmo = $urandom_range(12, 1);
          td  = ($urandom_range(1, 0) == 1) ? mlen(ty, tmo) : $urandom_range(mlen(ty, tmo), 1);
          twd = $urandom_range(6, 0);
          th  = ($urandom_range(1, 0) == 1) ? 23 : $urandom_range(23, 0);
          tmi = ($urandom_range(1, 0) == 1) ? 59 : $urandom_range(59, 0);
          ts  = ($urandom_range(3, 0) != 0) ? 59 : $urandom_range(59, 0);
        end
      endcase
      load_t();
      wr(8, 0);
      wr(9, 2); wr(9, 9);
      ticks(256);
      wr(9, 0);
      model_sec();
      read_t(v);
      chk($sformatf("R4 R5 advance case %0d", i), v, exp_time());
      rd(8, r);
      chk($sformatf("R6 carry after case %0d", i), r, 16'h0080);
    end

    // R8: adjust rounding
    set_t(2023, 12, 31, 6, 23, 59, 45);
    load_t();
    wr(9, 2); wr(9, 9);
    ticks(100);
    wr(9, 8'h0D);
    rd(0, r); chk("R8 adjust clears sub-second", r, 16'd0);
    rd(9, r); chk("R8 adjust bit reads zero", r, 16'h0009);
    wr(9, 0);
    ts = 59; model_sec();
    read_t(v); chk("R8 round up carries to new year", v, exp_time());
    set_t(2023, 6, 15, 3, 10, 20, 29);
    load_t();
    wr(9, 8'h0D); wr(9, 0);
    ts = 0;
    read_t(v); chk("R8 round down clears seconds", v, exp_time());

    // R9 / R10: periodic rates
    for (int c = 1; c < 8; c++) begin
      wr(9, 2); wr(9, (c << 4) | 9);
      ticks(period[c] - 1);
      rd(9, r); chk($sformatf("R9 code %0d not yet", c), r[7], 1'b0);
      ticks(1);
      rd(9, r); chk($sformatf("R9 code %0d flag", c), r[7], 1'b1);
      chk($sformatf("R10 code %0d irq", c), periodic_irq, 1'b1);
      wr(9, (c << 4) | 9);
      rd(9, r); chk($sformatf("R9 code %0d cleared", c), r[7], 1'b0);
      chk($sformatf("R10 code %0d irq cleared", c), periodic_irq, 1'b0);
    end
    wr(9, 2); wr(9, 9);
    ticks(300);
    rd(9, r); chk("R9 code 0 never sets", r[7], 1'b0);
    chk("R10 code 0 irq low", periodic_irq, 1'b0);
    wr(9, 2); wr(9, 8'h39);
    ticks(16);
    wr(9, 8'h89);
    rd(9, r); chk("R9 write one keeps flag", r, 16'h0089);
    chk("R10 irq masked by rate zero", periodic_irq, 1'b0);

    // R11: control readback
    wr(9, 8'h7B);
    rd(9, r); chk("R11 control readback", r, 16'h007B);
    wr(9, 8'h7D);
    rd(9, r); chk("R11 adjust bit reads zero", r, 16'h0079);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule